// File: doc/BRIEF.md
# Packet RAM Burst Transfer Engine

This block moves one packet payload between a local byte buffer and the packet memory of an external radio transceiver over a serial peripheral interface (SPI, mode 0, chip enable active low). The user pulses `start` with a direction. For a transmit, the engine first reads the transceiver's transmit length register. It then writes that register back with the low 7-bit length field replaced by the payload length plus two, which accounts for the two CRC bytes the transceiver appends. Finally it streams the payload as 16-bit words in a single burst.

For a receive, the engine reads the receive length register and derives the payload length from it. If the payload is empty or larger than the user's limit, the engine reports that outcome and performs no burst. Otherwise it streams the words into the local buffer. The burst begins with two dummy bytes and ends by dropping a trailing pad byte when the payload length is odd. Within each word the byte with the odd index travels first. CRC generation and checking are left to the transceiver.

The control is a single state machine. Transmit path: `S_IDLE` → `S_TL_HDR` → `S_TL_HI` → `S_TL_LO` → `S_TL_GAP` → `S_TW_HDR` → `S_TW_HI` → `S_TW_LO` → `S_TW_GAP` → `S_TB_HDR` → (`S_TB_HI` → `S_TB_LO`) repeated once per word → `S_DONE` → `S_IDLE`; with zero words the path goes from `S_TB_HDR` straight to `S_DONE`. Receive path: `S_IDLE` → `S_RL_HDR` → `S_RL_HI` → `S_RL_LO` → `S_RL_GAP`. From `S_RL_GAP` an empty or overflowing length goes to `S_DONE`. Any other length goes to `S_RB_HDR` → `S_RB_DM0` → `S_RB_DM1` → (`S_RB_HI` → `S_RB_LO`) repeated once per word → `S_DONE`. Every byte state waits for one full byte on the serial link before it advances. The gap states and `S_DONE` last one cycle each.

Top module: `pkt_burst_engine`

## Requirements
- R1: A register access frame is a header byte followed by two data bytes, most significant bits first. The header is {read=1/write=0, 1'b0, 6-bit address}, and the 16-bit register travels high byte first. The interface is mode 0: `spi_sclk` idles low, `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled on the rising edge. Default addresses: transmit length 6'h03, receive length 6'h2D, transmit packet memory 6'h02, receive packet memory 6'h01.
- R2: On a transmit (`dir_rx`=0), the value written back to the transmit length register keeps bits 15:7 exactly as read and sets bits 6:0 to `tx_len`+2.
- R3: The transmit burst sends header {2'b00, 6'h02}, then ceil(`tx_len`/2) words. Word k sends buffer byte 2k+1 first and byte 2k second. When 2k+1 equals `tx_len`, the first byte sent is 8'h00. The operation ends with status 2'b00 and `pay_len` = `tx_len`.
- R4: `spi_ce_n` stays low without a break from a frame's header through its last byte, and goes high between frames. A transmit uses exactly 3 frames. A receive with a burst uses 2 frames. A receive without a burst uses 1 frame.
- R5: On a receive, the reported length L is bits 6:0 of the receive length register. The payload length is L−2 when L≥3 and 0 otherwise, and it appears on `pay_len` with `done`.
- R6: A payload length of 0 skips the burst, reports status 2'b01 and writes nothing to the local buffer.
- R7: A payload length greater than `rx_max` skips the burst, reports status 2'b10 and writes nothing to the local buffer. A payload equal to `rx_max` is accepted and reports status 2'b00.
- R8: The receive burst sends header {2'b10, 6'h01}. It discards the next two bytes and then reads (L−1)>>1 words. The first byte of word k is stored at index 2k+1 and the second at index 2k.
- R9: When 2k+3 equals L, the first byte of word k is a pad byte and is not stored. Exactly `pay_len` bytes are written to the buffer.
- R10: `busy` is high from the cycle after an accepted `start` until the operation ends. `done` is a one-cycle pulse with `busy` low in the following cycle. A `start` while `busy` is high is ignored.
- R11: After reset, `spi_ce_n` is high, `spi_sclk` is low, and `busy`, `done` and `buf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when idle |
| dir_rx | input | 1 | 1 = receive, 0 = transmit (sampled with `start`) |
| tx_len | input | 7 | Transmit payload length in bytes (sampled with `start`) |
| rx_max | input | 7 | Largest receive payload accepted (sampled with `start`) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | 00 success, 01 empty, 10 overflow |
| pay_len | output | 7 | Payload length of the last operation |
| buf_addr | output | 7 | Local buffer byte index |
| buf_rdata | input | 8 | Local buffer byte at `buf_addr`, valid in the same cycle |
| buf_we | output | 1 | Local buffer write strobe |
| buf_wdata | output | 8 | Byte to write at `buf_addr` |
| spi_ce_n | output | 1 | Transceiver chip enable, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |

## Verification
The assertions check the link rules on every cycle. A serial clock pulse only happens with chip enable low. Chip enable never rises while a byte is in flight, and the data line holds steady across each rising clock. Buffer writes occur only inside a frame. `done` lasts one cycle and is followed by idle. An empty result always carries a zero length, and an overflow result a length above the limit. Only the bench scenarios, which drive a behavioural transceiver, can show the data-level behaviour: the read-modify-write of the length field, the odd-byte-first word order, the pad byte on odd transmit lengths, the dropped dummy and pad bytes on receive, the frame count per operation, and the skip decisions at lengths 0, 2, 3 and at the limit.

// File: rtl/pkt_burst_pkg.sv
package pkt_burst_pkg;

    typedef enum logic [1:0] {
        XS_OK    = 2'b00,
        XS_EMPTY = 2'b01,
        XS_OVFL  = 2'b10
    } xfer_status_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_TL_HDR, S_TL_HI, S_TL_LO, S_TL_GAP,
        S_TW_HDR, S_TW_HI, S_TW_LO, S_TW_GAP,
        S_TB_HDR, S_TB_HI, S_TB_LO,
        S_RL_HDR, S_RL_HI, S_RL_LO, S_RL_GAP,
        S_RB_HDR, S_RB_DM0, S_RB_DM1, S_RB_HI, S_RB_LO,
        S_DONE
    } eng_state_e;

    // States during which one byte is shifted with chip enable low
    function automatic logic in_frame(eng_state_e s);
        return s inside {S_TL_HDR, S_TL_HI, S_TL_LO,
                         S_TW_HDR, S_TW_HI, S_TW_LO,
                         S_TB_HDR, S_TB_HI, S_TB_LO,
                         S_RL_HDR, S_RL_HI, S_RL_LO,
                         S_RB_HDR, S_RB_DM0, S_RB_DM1, S_RB_HI, S_RB_LO};
    endfunction

endpackage

// File: rtl/pkt_spi_byte.sv
module pkt_spi_byte #(
    parameter int HALF_CYC = 2,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              done,
    output logic              active,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BW = $clog2(BYTE_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            cnt    <= '0;
            bitn   <= '0;
            sclk   <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                tx_sh  <= tx_byte;
                bitn   <= '0;
                cnt    <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt == CNT_LAST) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == BIT_LAST) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign mosi    = tx_sh[BYTE_W-1];
    assign rx_byte = rx_sh;

    // R1
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R1
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

endmodule

// File: rtl/pkt_rx_len_decode.sv
module pkt_rx_len_decode #(
    parameter int LEN_W = 7
) (
    input  logic [LEN_W-1:0] rep_len,
    input  logic [LEN_W-1:0] max_len,
    output logic [LEN_W-1:0] pay_len,
    output logic [LEN_W-1:0] words,
    output logic             empty,
    output logic             ovfl
);
    localparam logic [LEN_W-1:0] CRC_BYTES = LEN_W'(2);
    localparam logic [LEN_W-1:0] MIN_REP   = LEN_W'(3);

    always_comb begin
        pay_len = (rep_len >= MIN_REP) ? (rep_len - CRC_BYTES) : '0;
        words   = (rep_len - LEN_W'(1)) >> 1;
        empty   = (pay_len == '0);
        ovfl    = (pay_len > max_len);
    end

endmodule

// File: rtl/pkt_burst_engine.sv
module pkt_burst_engine
    import pkt_burst_pkg::*;
#(
    parameter int LEN_W       = 7,
    parameter int BYTE_W      = 8,
    parameter int HALF_CYC    = 2,
    parameter int ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] TXLEN_ADDR = 6'h03,
    parameter logic [ADDR_W-1:0] RXLEN_ADDR = 6'h2D,
    parameter logic [ADDR_W-1:0] TXRAM_ADDR = 6'h02,
    parameter logic [ADDR_W-1:0] RXRAM_ADDR = 6'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_rx,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [LEN_W-1:0]  rx_max,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [LEN_W-1:0]  pay_len,
    output logic [LEN_W-1:0]  buf_addr,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              spi_ce_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int REG_W = 2 * BYTE_W;
    localparam int IDX_W = LEN_W + 1;
    localparam int PAD_W = LEN_W + 2;
    localparam logic [BYTE_W-1:0] PAD_BYTE = '0;
    localparam logic [BYTE_W-1:0] HDR_TL_RD = {2'b10, TXLEN_ADDR};
    localparam logic [BYTE_W-1:0] HDR_TL_WR = {2'b00, TXLEN_ADDR};
    localparam logic [BYTE_W-1:0] HDR_RL_RD = {2'b10, RXLEN_ADDR};
    localparam logic [BYTE_W-1:0] HDR_TB_WR = {2'b00, TXRAM_ADDR};
    localparam logic [BYTE_W-1:0] HDR_RB_RD = {2'b10, RXRAM_ADDR};

    eng_state_e state, state_n;

    logic [REG_W-1:0]  len_q;
    logic [LEN_W-1:0]  tx_len_q;
    logic [LEN_W-1:0]  rx_max_q;
    logic [LEN_W-1:0]  k_q;
    logic [LEN_W-1:0]  pay_len_q;
    xfer_status_e      status_q;
    logic              issued_q;
    logic              ce_n_q, busy_q, done_q;

    logic              sh_start, sh_done, sh_active;
    logic [BYTE_W-1:0] sh_tx, sh_rx;

    logic [LEN_W-1:0]  dec_pay, dec_words;
    logic              dec_empty, dec_ovfl;
    logic [LEN_W-1:0]  rep_len;

    logic [IDX_W-1:0]  idx_hi, idx_lo, tx_words;
    logic              tx_pad, rx_pad, last_tx, last_rx;
    logic [REG_W-1:0]  wr_word;

    // ---------------- helpers ----------------
    assign rep_len  = len_q[LEN_W-1:0];
    assign idx_hi   = {k_q, 1'b1};
    assign idx_lo   = {k_q, 1'b0};
    assign tx_words = ({1'b0, tx_len_q} + IDX_W'(1)) >> 1;
    assign last_tx  = ({1'b0, k_q} == (tx_words - IDX_W'(1)));
    assign last_rx  = (k_q == (dec_words - LEN_W'(1)));
    assign tx_pad   = (idx_hi == {1'b0, tx_len_q});
    assign rx_pad   = (({1'b0, idx_hi}) + PAD_W'(2)) == {2'b00, rep_len};
    assign wr_word  = {len_q[REG_W-1:LEN_W], tx_len_q + LEN_W'(2)};

    pkt_rx_len_decode #(.LEN_W(LEN_W)) u_dec (
        .rep_len (rep_len),
        .max_len (rx_max_q),
        .pay_len (dec_pay),
        .words   (dec_words),
        .empty   (dec_empty),
        .ovfl    (dec_ovfl)
    );

    assign sh_start = in_frame(state) && !issued_q && !sh_active;

    pkt_spi_byte #(.HALF_CYC(HALF_CYC), .BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .rx_byte (sh_rx),
        .done    (sh_done),
        .active  (sh_active),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start) state_n = dir_rx ? S_RL_HDR : S_TL_HDR;
            S_TL_HDR: if (sh_done) state_n = S_TL_HI;
            S_TL_HI:  if (sh_done) state_n = S_TL_LO;
            S_TL_LO:  if (sh_done) state_n = S_TL_GAP;
            S_TL_GAP: state_n = S_TW_HDR;
            S_TW_HDR: if (sh_done) state_n = S_TW_HI;
            S_TW_HI:  if (sh_done) state_n = S_TW_LO;
            S_TW_LO:  if (sh_done) state_n = S_TW_GAP;
            S_TW_GAP: state_n = S_TB_HDR;
            S_TB_HDR: if (sh_done) state_n = (tx_words == '0) ? S_DONE : S_TB_HI;
            S_TB_HI:  if (sh_done) state_n = S_TB_LO;
            S_TB_LO:  if (sh_done) state_n = last_tx ? S_DONE : S_TB_HI;
            S_RL_HDR: if (sh_done) state_n = S_RL_HI;
            S_RL_HI:  if (sh_done) state_n = S_RL_LO;
            S_RL_LO:  if (sh_done) state_n = S_RL_GAP;
            S_RL_GAP: state_n = (dec_empty || dec_ovfl) ? S_DONE : S_RB_HDR;
            S_RB_HDR: if (sh_done) state_n = S_RB_DM0;
            S_RB_DM0: if (sh_done) state_n = S_RB_DM1;
            S_RB_DM1: if (sh_done) state_n = S_RB_HI;
            S_RB_HI:  if (sh_done) state_n = S_RB_LO;
            S_RB_LO:  if (sh_done) state_n = last_rx ? S_DONE : S_RB_HI;
            S_DONE:   state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // ---------------- byte source and buffer side ----------------
    always_comb begin
        sh_tx     = '0;
        buf_addr  = '0;
        buf_we    = 1'b0;
        buf_wdata = sh_rx;
        unique case (state)
            S_TL_HDR: sh_tx = HDR_TL_RD;
            S_RL_HDR: sh_tx = HDR_RL_RD;
            S_TW_HDR: sh_tx = HDR_TL_WR;
            S_TW_HI:  sh_tx = wr_word[REG_W-1:BYTE_W];
            S_TW_LO:  sh_tx = wr_word[BYTE_W-1:0];
            S_TB_HDR: sh_tx = HDR_TB_WR;
            S_RB_HDR: sh_tx = HDR_RB_RD;
            S_TB_HI: begin
                buf_addr = idx_hi[LEN_W-1:0];
                sh_tx    = tx_pad ? PAD_BYTE : buf_rdata;
            end
            S_TB_LO: begin
                buf_addr = idx_lo[LEN_W-1:0];
                sh_tx    = buf_rdata;
            end
            S_RB_HI: begin
                buf_addr = idx_hi[LEN_W-1:0];
                buf_we   = sh_done && !rx_pad;
            end
            S_RB_LO: begin
                buf_addr = idx_lo[LEN_W-1:0];
                buf_we   = sh_done;
            end
            default: sh_tx = '0;
        endcase
    end

    // ---------------- registered outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q    <= 1'b1;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            len_q     <= '0;
            tx_len_q  <= '0;
            rx_max_q  <= '0;
            k_q       <= '0;
            pay_len_q <= '0;
            status_q  <= XS_OK;
            issued_q  <= 1'b0;
        end else begin
            ce_n_q <= !in_frame(state_n);
            busy_q <= (state_n != S_IDLE);
            done_q <= (state_n == S_DONE);

            if (sh_start)     issued_q <= 1'b1;
            else if (sh_done) issued_q <= 1'b0;

            if (state == S_IDLE && start) begin
                tx_len_q  <= tx_len;
                rx_max_q  <= rx_max;
                k_q       <= '0;
                status_q  <= XS_OK;
                pay_len_q <= dir_rx ? '0 : tx_len;
            end

            if (sh_done) begin
                unique case (state)
                    S_TL_HI, S_RL_HI: len_q[REG_W-1:BYTE_W] <= sh_rx;
                    S_TL_LO, S_RL_LO: len_q[BYTE_W-1:0]     <= sh_rx;
                    S_TB_LO, S_RB_LO: k_q <= k_q + 1'b1;
                    default: ;
                endcase
            end

            if (state == S_RL_GAP) begin
                pay_len_q <= dec_pay;
                if (dec_empty)     status_q <= XS_EMPTY;
                else if (dec_ovfl) status_q <= XS_OVFL;
                else               status_q <= XS_OK;
            end
        end
    end

    assign spi_ce_n = ce_n_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign status   = status_q;
    assign pay_len  = pay_len_q;

    // ---------------- assertions ----------------
    // R1
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_ce_n);

    // R4
    ce_mid_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_ce_n) |-> !sh_active);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6
    empty_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == XS_EMPTY) |-> (pay_len == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == XS_OVFL) |-> (pay_len > rx_max_q));

    // R8
    we_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !spi_ce_n);

endmodule

// File: tb/pkt_burst_engine_tb.sv
`timescale 1ns/1ps
module pkt_burst_engine_tb;
    localparam logic [5:0] A_TXLEN = 6'h03;
    localparam logic [5:0] A_RXLEN = 6'h2D;
    localparam logic [5:0] A_TXRAM = 6'h02;
    localparam logic [5:0] A_RXRAM = 6'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir_rx = 1'b0;
    logic [6:0] tx_len = '0;
    logic [6:0] rx_max = '0;
    logic       busy, done, buf_we, spi_ce_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;
    logic [1:0] status;
    logic [6:0] pay_len, buf_addr;
    logic [7:0] buf_rdata, buf_wdata;

    always #2 clk = ~clk;

    pkt_burst_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx),
        .tx_len(tx_len), .rx_max(rx_max), .busy(busy), .done(done),
        .status(status), .pay_len(pay_len), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .spi_ce_n(spi_ce_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // local buffer
    logic [7:0] lbuf [0:127];
    int we_cnt = 0;
    assign buf_rdata = lbuf[buf_addr];
    always @(posedge clk) if (buf_we) begin
        lbuf[buf_addr] <= buf_wdata;
        we_cnt = we_cnt + 1;
    end

    // behavioural transceiver
    logic [15:0] reg_txlen, reg_rxlen;
    logic [7:0]  tx_cap [0:255];
    logic [7:0]  rx_stream [0:255];
    int tx_cap_n = 0, frames = 0, rd_bursts = 0, wr_bursts = 0;
    int bitc = 0, bytec = 0;
    logic [7:0] sh_in = '0, out_byte = '0, hdr = '0, wr_hi = '0;

    task slave_byte();
        logic [7:0] b;
        logic [15:0] v;
        int m;
        b = sh_in;
        m = bytec + 1;
        if (bytec == 0) begin
            hdr = b;
            if (b == {2'b10, A_RXRAM}) rd_bursts++;
            if (b == {2'b00, A_TXRAM}) wr_bursts++;
        end else if (!hdr[7]) begin
            if (hdr[5:0] == A_TXRAM) begin
                tx_cap[tx_cap_n & 255] = b;
                tx_cap_n++;
            end else if (bytec == 1) wr_hi = b;
            else if (bytec == 2 && hdr[5:0] == A_TXLEN) reg_txlen = {wr_hi, b};
        end
        out_byte = 8'h00;
        if (hdr[7]) begin
            if (hdr[5:0] == A_RXRAM)
                out_byte = (m == 1) ? 8'hA5 : (m == 2) ? 8'h5A : rx_stream[(m - 3) & 255];
            else begin
                v = (hdr[5:0] == A_TXLEN) ? reg_txlen : reg_rxlen;
                out_byte = (m == 1) ? v[15:8] : (m == 2) ? v[7:0] : 8'h00;
            end
        end
    endtask

    always @(negedge spi_ce_n) begin
        bitc = 0; bytec = 0; out_byte = 8'h00; spi_miso = 1'b0; frames++;
    end
    always @(posedge spi_sclk) if (!spi_ce_n) begin
        sh_in = {sh_in[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            slave_byte();
            bytec++;
        end
    end
    always @(negedge spi_sclk) if (!spi_ce_n) spi_miso = out_byte[7 - bitc];

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    logic [1:0] got_st;
    logic [6:0] got_len;

    task automatic run_op(input bit dir, input int txl, input int rmax, input bit poke);
        bit seen = 0;
        frames = 0; rd_bursts = 0; wr_bursts = 0; tx_cap_n = 0; we_cnt = 0;
        @(negedge clk);
        start = 1'b1; dir_rx = dir; tx_len = 7'(txl); rx_max = 7'(rmax);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            start  = (poke && i == 40);
            dir_rx = poke ? 1'b1 : dir;
            if (done) begin seen = 1; break; end
        end
        start = 1'b0;
        chk(seen, "R10 done seen", int'(seen), 1);
        got_st = status; got_len = pay_len;
        @(negedge clk);
        chk(!done && !busy, "R10 done one cycle", int'({done, busy}), 0);
    endtask

    task automatic test_tx(input int L, input logic [8:0] upper, input bit poke);
        int bad = 0;
        int w = (L + 1) / 2;
        for (int i = 0; i < 128; i++) lbuf[i] = 8'(8'h10 + i * 7);
        reg_txlen = {upper, 7'h55};
        run_op(1'b0, L, 0, poke);
        chk(reg_txlen == {upper, 7'(L + 2)}, "R1 R2 length rmw", int'(reg_txlen), int'({upper, 7'(L + 2)}));
        chk(tx_cap_n == 2 * w, "R3 word count", tx_cap_n, 2 * w);
        for (int k = 0; k < w; k++) begin
            logic [7:0] e_hi;
            e_hi = (2 * k + 1 < L) ? lbuf[2 * k + 1] : 8'h00;
            if (tx_cap[2 * k] !== e_hi) bad++;
            if (tx_cap[2 * k + 1] !== lbuf[2 * k]) bad++;
        end
        chk(bad == 0, "R3 byte order and pad", bad, 0);
        chk(got_st == 2'b00 && got_len == 7'(L), "R3 status and length", int'({got_st, got_len}), L);
        chk(frames == 3 && wr_bursts == 1, "R4 tx frames", frames, 3);
        if (poke) chk(rd_bursts == 0 && frames == 3, "R10 start ignored while busy", rd_bursts, 0);
    endtask

    task automatic test_rx(input int rep, input int rmax);
        logic [7:0] expb [0:127];
        int bad = 0;
        int ep = (rep >= 3) ? rep - 2 : 0;
        int es = (ep == 0) ? 1 : (ep > rmax) ? 2 : 0;
        for (int i = 0; i < 128; i++) begin lbuf[i] = 8'hEE; expb[i] = 8'hEE; end
        for (int j = 0; j < 256; j++) rx_stream[j] = 8'(8'h30 + j * 5);
        reg_rxlen = {9'h0A7, 7'(rep)};
        if (es == 0)
            for (int k = 0; k < (rep - 1) / 2; k++) begin
                if (2 * k + 3 != rep) expb[2 * k + 1] = rx_stream[2 * k];
                expb[2 * k] = rx_stream[2 * k + 1];
            end
        run_op(1'b1, 0, rmax, 1'b0);
        chk(got_len == 7'(ep), "R5 payload length", int'(got_len), ep);
        if (es == 1) chk(got_st == 2'b01, "R6 empty status", int'(got_st), 1);
        else if (es == 2) chk(got_st == 2'b10, "R7 overflow status", int'(got_st), 2);
        else chk(got_st == 2'b00, "R7 accepted status", int'(got_st), 0);
        chk(frames == ((es == 0) ? 2 : 1), "R4 rx frames", frames, (es == 0) ? 2 : 1);
        for (int i = 0; i < 128; i++) if (lbuf[i] !== expb[i]) bad++;
        chk(bad == 0, "R8 buffer contents", bad, 0);
        chk(we_cnt == ((es == 0) ? ep : 0), "R9 bytes written", we_cnt, (es == 0) ? ep : 0);
    endtask

    initial begin
        #(4 * 190000);
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
        $finish;
    end

    initial begin
        reg_txlen = '0; reg_rxlen = '0;
        for (int i = 0; i < 128; i++) lbuf[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(spi_ce_n && !spi_sclk && !busy && !done && !buf_we, "R11 reset state",
            int'({spi_ce_n, spi_sclk, busy, done, buf_we}), 16);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_tx(6, 9'h1F3, 1'b0);
        test_tx(5, 9'h0C1, 1'b1);
        test_tx(1, 9'h155, 1'b0);
        test_rx(8, 20);
        test_rx(7, 20);
        test_rx(3, 5);
        test_rx(2, 20);
        test_rx(0, 20);
        test_rx(20, 10);
        test_rx(12, 10);
        test_rx(127, 127);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule